// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry/Link Flag Update

This unit shifts or rotates a 16-bit or 32-bit operand by a 6-bit count. It offers six operations: logical right, logical left, arithmetic right, arithmetic left, rotate right and rotate left. The result is computed combinationally and captured in an output register. Alongside the result, a 16-bit status word is captured from an input copy. Its carry bit and its link bit are both replaced by a single new flag. Every other status bit passes through unchanged. The flag normally holds the last bit moved out of the operand. Arithmetic left shifts use it as a signed-overflow indicator instead. Counts beyond the operand width follow fixed saturation rules.

The surrounding datapath presents an operand, a count, an operation code, a width select and the current status word with a one-cycle valid strobe. One clock later, the unit returns the result and the updated status word. When no strobe is given, the outputs keep their last values.

Top module: `shifter_cl`

## Requirements
- R1: Operation codes are 0 logical right, 1 logical left, 2 arithmetic right, 3 arithmetic left, 4 rotate right, 5 rotate left. With `wide`=0, only operand bits 15:0 are used, the width N is 16, and result bits 31:16 are zero. With `wide`=1, N is 32.
- R2: For a logical shift with count k in 1..N, the result is the operand shifted by k with zero fill. The flag equals operand bit k-1 for a right shift and operand bit N-k for a left shift.
- R3: For a logical shift with count greater than N, the result is 0 and the flag is cleared.
- R4: For an arithmetic right shift with count k in 1..N, the result is sign-filled and the flag equals operand bit k-1. For k greater than N, a negative operand gives an all-ones result with the flag set, and any other operand gives 0 with the flag cleared.
- R5: For an arithmetic left shift with count k in 1..N-1, the result is the operand shifted left by k with zero fill. The flag is set exactly when the top k+1 operand bits are not all equal.
- R6: For an arithmetic left shift with count N or more, the result is 0 and the flag is set exactly when the operand was nonzero.
- R7: A rotate uses the effective count ((count-1) mod N)+1, so a count of 0 means N. The flag equals operand bit k-1 for a right rotate and operand bit N-k for a left rotate, where k is the effective count.
- R8: For a non-rotate operation with count 0, and for the unused codes 6 and 7, the result equals the operand and the flag is cleared.
- R9: On a clock edge with `in_valid` high, status bits 15 (carry) and 13 (link) of `keys_out` both take the new flag. All other bits copy `keys_in`. `result` and `keys_out` appear one cycle after the strobe, and `out_valid` is the strobe delayed by one cycle.
- R10: On a clock edge with `in_valid` low, `result` and `keys_out` keep their values.
- R11: Synchronous active-high reset clears `result`, `keys_out` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code |
| wide | input | 1 | 1 selects 32-bit, 0 selects 16-bit |
| operand | input | 32 | Value to shift or rotate |
| count | input | 6 | Shift or rotate count |
| keys_in | input | 16 | Current status word |
| out_valid | output | 1 | Registered strobe |
| result | output | 32 | Registered result |
| keys_out | output | 16 | Registered status word with carry/link updated |

## Verification
A fixed sweep crosses every operation code and both widths with the counts 0, 1, 2, 15, 16, 17, 31, 32, 33 and 63. It applies each combination to operands chosen to separate the flag rules. A lone top bit or a lone bit 15 shows whether the flag comes from the correct end. All ones against a positive maximum distinguishes sign fill from zero fill and detects overflow on left arithmetic shifts. A mixed pattern reveals rotate wrap errors. The sweep is followed by pseudo-random operations with random idle gaps and random status words, which exercise the hold behaviour and show whether untouched status bits leak or stay put.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SH_LSR = 3'd0,
    SH_LSL = 3'd1,
    SH_ASR = 3'd2,
    SH_ASL = 3'd3,
    SH_ROR = 3'd4,
    SH_ROL = 3'd5
  } shf_op_e;
endpackage

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int W    = 16,
  parameter int CNTW = 6
) (
  input  logic [W-1:0]    opnd,
  input  logic [CNTW-1:0] cnt,
  input  logic [2:0]      op,
  output logic [W-1:0]    res,
  output logic            flg
);
  localparam int LGW = $clog2(W);
  localparam logic [CNTW:0] WCNT = (CNTW+1)'(W);
  localparam logic [LGW:0]  WK   = (LGW+1)'(W);

  logic [CNTW:0]  c_ext;
  logic           in_rng;
  logic [LGW-1:0] cm1;     // count-1 modulo W: bit index of last bit out
  logic [LGW:0]   k_rot;   // normalized rotate count 1..W
  logic [W-1:0]   r_dn, l_up, a_dn, ror_res, rol_res;
  logic [W-1:0]   top_mask, top_bits;
  logic           asl_ovf;
  logic           is_rot;

  assign c_ext    = {1'b0, cnt};
  assign in_rng   = (cnt != '0) && (c_ext <= WCNT);
  assign cm1      = cnt[LGW-1:0] - LGW'(1);
  assign k_rot    = {1'b0, cm1} + (LGW+1)'(1);
  assign r_dn     = opnd >> cnt;
  assign l_up     = opnd << cnt;
  assign a_dn     = $signed(opnd) >>> cnt;
  assign ror_res  = (opnd >> k_rot) | (opnd << (WK - k_rot));
  assign rol_res  = (opnd << k_rot) | (opnd >> (WK - k_rot));
  assign top_mask = ~({W{1'b1}} >> (c_ext + (CNTW+1)'(1)));
  assign top_bits = opnd & top_mask;
  assign asl_ovf  = (top_bits != '0) && (top_bits != top_mask);
  assign is_rot   = (op == SH_ROR) || (op == SH_ROL);

  always_comb begin
    res = opnd;
    flg = 1'b0;
    if (is_rot || cnt != '0) begin
      case (op)
        SH_LSR: begin
          res = r_dn;
          flg = in_rng ? opnd[cm1] : 1'b0;
        end
        SH_LSL: begin
          res = l_up;
          flg = in_rng ? opnd[LGW'(W-1) - cm1] : 1'b0;
        end
        SH_ASR: begin
          res = a_dn;
          flg = in_rng ? opnd[cm1] : opnd[W-1];
        end
        SH_ASL: begin
          if (c_ext < WCNT) begin
            res = l_up;
            flg = asl_ovf;
          end else begin
            res = '0;
            flg = |opnd;
          end
        end
        SH_ROR: begin
          res = ror_res;
          flg = opnd[cm1];
        end
        SH_ROL: begin
          res = rol_res;
          flg = opnd[LGW'(W-1) - cm1];
        end
        default: begin
          res = opnd;
          flg = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/shf_reg.sv
module shf_reg #(
  parameter int RW = 32,
  parameter int KW = 16,
  parameter int CB = 15,
  parameter int LB = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [RW-1:0] d_res,
  input  logic          d_flg,
  input  logic [KW-1:0] keys_in,
  output logic          q_valid,
  output logic [RW-1:0] q_res,
  output logic [KW-1:0] q_keys
);
  logic [KW-1:0] merged;

  always_comb begin
    merged     = keys_in;
    merged[CB] = d_flg;
    merged[LB] = d_flg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_res   <= '0;
      q_keys  <= '0;
    end else begin
      q_valid <= en;
      if (en) begin
        q_res  <= d_res;
        q_keys <= merged;
      end
    end
  end
endmodule

// File: rtl/shifter_cl.sv
module shifter_cl
  import shf_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int CNT_W    = 6,
  parameter int KEY_W    = 16,
  parameter int C_BIT    = 15,
  parameter int L_BIT    = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [WIDE_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic [KEY_W-1:0]  keys_in,
  output logic              out_valid,
  output logic [WIDE_W-1:0] result,
  output logic [KEY_W-1:0]  keys_out
);
  localparam logic [KEY_W-1:0] FLAG_MASK = (KEY_W'(1) << C_BIT) | (KEY_W'(1) << L_BIT);

  logic [WIDE_W-1:0] res_sel [2];
  logic [1:0]        flg_sel;

  for (genvar g = 0; g < 2; g++) begin : g_w
    localparam int GW = (g == 0) ? NARROW_W : WIDE_W;
    logic [GW-1:0] c_res;
    logic          c_flg;
    shf_core #(.W(GW), .CNTW(CNT_W)) u_core (
      .opnd (operand[GW-1:0]),
      .cnt  (count),
      .op   (op),
      .res  (c_res),
      .flg  (c_flg)
    );
    assign res_sel[g] = WIDE_W'(c_res);
    assign flg_sel[g] = c_flg;
  end

  shf_reg #(.RW(WIDE_W), .KW(KEY_W), .CB(C_BIT), .LB(L_BIT)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .en      (in_valid),
    .d_res   (res_sel[wide]),
    .d_flg   (flg_sel[wide]),
    .keys_in (keys_in),
    .q_valid (out_valid),
    .q_res   (result),
    .q_keys  (keys_out)
  );

  logic [CNT_W:0] width_cnt;
  assign width_cnt = wide ? (CNT_W+1)'(WIDE_W) : (CNT_W+1)'(NARROW_W);

  AST_CL_PAIR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> keys_out[C_BIT] == keys_out[L_BIT]); // R9

  AST_KEEP_OTHERS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (keys_out & ~FLAG_MASK) == ($past(keys_in) & ~FLAG_MASK)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(keys_out)); // R10

  AST_LOGIC_OVR: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == SH_LSR || op == SH_LSL) && ({1'b0, count} > width_cnt)
    |=> result == '0 && !keys_out[C_BIT]); // R3

  AST_ZERO_CNT: assert property (@(posedge clk) disable iff (rst)
    in_valid && op <= 3'd3 && count == '0 && wide
    |=> result == $past(operand) && !keys_out[C_BIT]); // R8

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
    in_valid && !wide |=> result[WIDE_W-1:NARROW_W] == '0); // R1

  AST_ROT_ONES: assert property (@(posedge clk) disable iff (rst)
    in_valid && (op == SH_ROR || op == SH_ROL) && !wide
    |=> $countones(result) == $countones($past(operand[NARROW_W-1:0]))); // R7
endmodule

// File: tb/tb_shifter_cl.sv
module tb_shifter_cl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b0;
  logic [31:0] operand = '0;
  logic [5:0]  count = '0;
  logic [15:0] keys_in = '0;
  logic        out_valid;
  logic [31:0] result;
  logic [15:0] keys_out;

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  logic [31:0] exp_res = '0;
  logic [15:0] exp_keys = '0;
  logic        exp_v = 1'b0;
  bit          exp_narrow = 1'b0;
  string       tag = "R11";
  logic [31:0] rs = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  shifter_cl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
    .operand(operand), .count(count), .keys_in(keys_in),
    .out_valid(out_valid), .result(result), .keys_out(keys_out)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Bit-serial behavioural model of the requirements
  task automatic model(input logic [2:0] o, input bit w, input logic [31:0] opd,
                       input logic [5:0] c, output logic [31:0] r, output bit f);
    int n = w ? 32 : 16;
    logic [31:0] mask = w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] v = opd & mask;
    bit sgn = v[n-1];
    int k;
    f = 1'b0;
    if (o <= 3 && c == 0) begin r = v; return; end
    case (o)
      3'd0: for (int i = 0; i < c; i++) begin f = v[0]; v = v >> 1; end
      3'd1: for (int i = 0; i < c; i++) begin f = v[n-1]; v = (v << 1) & mask; end
      3'd2: for (int i = 0; i < c; i++) begin f = v[0]; v = v >> 1; v[n-1] = sgn; end
      3'd3: begin
        if (c >= n) begin f = (v != 0); v = 0; end
        else for (int i = 0; i < c; i++) begin
          v = (v << 1) & mask;
          if (v[n-1] != sgn) f = 1'b1;
        end
      end
      3'd4: begin
        k = ((int'(c) + n - 1) % n) + 1;
        for (int i = 0; i < k; i++) begin
          f = v[0];
          v = (v >> 1) | (32'(v[0]) << (n-1));
        end
      end
      3'd5: begin
        k = ((int'(c) + n - 1) % n) + 1;
        for (int i = 0; i < k; i++) begin
          f = v[n-1];
          v = ((v << 1) & mask) | 32'(v[n-1]);
        end
      end
      default: f = 1'b0;
    endcase
    r = v;
  endtask

  function automatic string tag_of(input logic [2:0] o, input bit w, input logic [5:0] c);
    int n = w ? 32 : 16;
    if (o > 5 || (o <= 3 && c == 0)) return "R8";
    case (o)
      3'd0, 3'd1: return (c > n) ? "R3" : "R2";
      3'd2: return "R4";
      3'd3: return (c >= n) ? "R6" : "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    vectors++;
    if (result !== exp_res || keys_out[15] !== exp_keys[15] || keys_out[13] !== exp_keys[13]
        || out_valid !== exp_v) begin
      errs++;
      $display("FAIL %s: res=%h keys=%h v=%b expected res=%h keys=%h v=%b",
               tag, result, keys_out, out_valid, exp_res, exp_keys, exp_v);
    end
    vectors++;
    if ((keys_out & 16'h5FFF) !== (exp_keys & 16'h5FFF)) begin
      errs++;
      $display("FAIL R9: other status bits %h expected %h", keys_out & 16'h5FFF, exp_keys & 16'h5FFF);
    end
    if (exp_narrow && exp_v) begin
      vectors++;
      if (result[31:16] !== 16'h0) begin
        errs++;
        $display("FAIL R1: narrow upper result %h expected 0000", result[31:16]);
      end
    end
  endtask

  task automatic step(input bit v, input logic [2:0] o, input bit w, input logic [31:0] opd,
                      input logic [5:0] c, input logic [15:0] k);
    logic [31:0] r;
    bit f;
    @(negedge clk);
    compare();
    in_valid = v; op = o; wide = w; operand = opd; count = c; keys_in = k;
    exp_v = v;
    if (v) begin
      model(o, w, opd, c, r, f);
      exp_res = r;
      exp_keys = k;
      exp_keys[15] = f;
      exp_keys[13] = f;
      exp_narrow = !w;
      tag = {tag_of(o, w, c), "/R9"};
    end else begin
      tag = "R10";
    end
  endtask

  logic [31:0] pats [7] = '{32'h8000_0000, 32'h0000_8000, 32'h0000_0001, 32'hFFFF_FFFF,
                            32'h7FFF_7FFF, 32'h1234_5678, 32'h0000_4000};
  logic [5:0]  cnts [10] = '{6'd0, 6'd1, 6'd2, 6'd15, 6'd16, 6'd17, 6'd31, 6'd32, 6'd33, 6'd63};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // First step checks the post-reset state (R11)
    step(1'b0, 3'd0, 1'b0, 32'h0, 6'd0, 16'h0);
    tag = "R11";
    for (int o = 0; o < 8; o++)
      for (int w = 0; w < 2; w++)
        for (int ci = 0; ci < 10; ci++)
          for (int pi = 0; pi < 7; pi++) begin
            rs = nxt(rs);
            step(1'b1, 3'(o), w[0], pats[pi], cnts[ci], rs[15:0]);
          end
    for (int i = 0; i < 1500; i++) begin
      rs = nxt(rs);
      step(rs[1:0] != 2'b00, rs[4:2] % 3'd6 + 3'(rs[5] & rs[6] & rs[7]) * 3'd6 > 3'd7 ? 3'd0 : rs[4:2],
           rs[8], nxt(rs), rs[14:9], rs[31:16]);
    end
    step(1'b0, 3'd0, 1'b0, 32'h0, 6'd0, 16'h0);
    step(1'b0, 3'd0, 1'b0, 32'h0, 6'd0, 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule